// File: doc/BRIEF.md
# Line Switch State Controller

This block is the control logic for a telephone line-card switch array. Two mode inputs select a line state: talk, ringing, test or all-off. A latch-enable input freezes the selected mode so that later changes on the mode inputs are ignored. The block drives one enable for each switch group: the break switches, the ringing return switch, the ringing switch and the test switches. All switch enables are registered.

An active-low override and a thermal-fault flag act outside the latch and take priority over the decoded mode. When the override is asserted, the return, break and test switches open on the next clock edge. A ringing switch that is closed stays closed until a ringing-current zero crossing is reported. Only then does the array reach the all-off state. Break-before-make is kept: no switch closes again until the override is released and no thermal fault is present. A thermal fault opens every switch at once and pulls the status output low.

Top module: `line_sw_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four switch enables go to 0 and `fault_n` goes to 1.
- R2: With `hold_en` = 0, the code on (`ring_sel`, `test_sel`) appears on the switch enables one clock after it is sampled.
- R3: With `hold_en` = 1, the switch enables keep the decode of the code sampled in the last cycle with `hold_en` = 0, whatever the mode inputs do.
- R4: Code `ring_sel`=1, `test_sel`=0 gives `rret_en`=1 and `ring_en`=1, with `brk_en`=0 and `tst_en`=0.
- R5: Code 0,0 gives `brk_en`=1 and the other three enables 0.
- R6: Code 0,1 gives only `tst_en`=1. Code 1,1 gives all four enables 0.
- R7: One clock after `kill_n` is sampled low, `brk_en`, `rret_en` and `tst_en` are 0. No enable rises while `kill_n` stays low, whatever the mode inputs or `hold_en` do.
- R8: If `ring_en` is 1 when `kill_n` is sampled low, `ring_en` stays 1 until `zc_pulse` is sampled high. It is 0 one clock after that.
- R9: If `ring_en` is 0 when `kill_n` is sampled low, the block reaches all-off at once and stays there without any `zc_pulse`.
- R10: From all-off, the decoded mode returns one clock after `kill_n` is sampled high with `therm_fault` low. While `therm_fault` is high, the block stays all-off.
- R11: One clock after `therm_fault` is sampled high, all four enables are 0 and `fault_n` is 0. This holds even while the ringing switch is waiting for a zero crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ring_sel | input | 1 | Mode input, ringing bit |
| test_sel | input | 1 | Mode input, test bit |
| hold_en | input | 1 | 1 freezes the mode code, 0 lets it through |
| kill_n | input | 1 | Forced all-off request, active low |
| therm_fault | input | 1 | Thermal fault flag, active high |
| zc_pulse | input | 1 | Ringing-current zero crossing seen |
| brk_en | output | 1 | Break switches closed |
| rret_en | output | 1 | Ringing return switch closed |
| ring_en | output | 1 | Ringing switch closed |
| tst_en | output | 1 | Test switches closed |
| fault_n | output | 1 | Thermal status, low on fault |

## Verification
Some rules are checked by assertions on every cycle:
- the frozen code stays stable;
- the override opens the break, return and test switches;
- no switch closes during the override;
- the ringing switch holds until a zero crossing;
- a thermal fault forces everything off;
- break and ringing switches never close together.

Only the bench scenarios can show the exact decode of each mode code. They also cover which code a freeze captures and when the decoded mode returns after the override is released.

// File: rtl/line_sw_pkg.sv
// Shared types for the line switch controller.
// Assumes one enable bit per switch group.
package line_sw_pkg;

    typedef struct packed {
        logic brk;
        logic rret;
        logic ring;
        logic tst;
    } sw_set_t;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_WAIT_ZC = 2'd1,
        ST_OFF     = 2'd2
    } seq_state_t;

    localparam sw_set_t SW_NONE = '{brk: 1'b0, rret: 1'b0, ring: 1'b0, tst: 1'b0};

endpackage

// File: rtl/sw_mode_latch.sv
// Transparent mode latch, built as a register plus bypass.
// When hold_en is low, the live code passes through and is captured.
// When hold_en is high, the last captured code is used.
// Assumes the inputs are synchronous to clk.
module sw_mode_latch #(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] live_code,
    input  logic              hold_en,
    output logic [CODE_W-1:0] eff_code
);

    logic [CODE_W-1:0] held_q;
    logic              armed_q;

    // Capture the live code while the latch is open.
    always_ff @(posedge clk) begin
        if (!rst_n)        held_q <= '0;
        else if (!hold_en) held_q <= live_code;
    end

    // Mark that one full cycle has passed since reset, for the $past check.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // Select the live code or the held code.
    always_comb eff_code = hold_en ? held_q : live_code;

    // R3: while the freeze lasts, the effective code does not move.
    p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (hold_en && $past(hold_en)) |-> $stable(eff_code));

endmodule

// File: rtl/sw_mode_decode.sv
// Maps a mode code {ringing, test} to the set of switches to close.
// Purely combinational; the code 1,1 decodes to all-off.
module sw_mode_decode
    import line_sw_pkg::*;
#(
    parameter int CODE_W = 2
) (
    input  logic [CODE_W-1:0] code,
    output sw_set_t           sw
);

    // Decode table, one mode per code.
    always_comb begin
        sw = SW_NONE;
        unique case (code)
            2'b00: sw.brk = 1'b1;
            2'b10: begin
                sw.rret = 1'b1;
                sw.ring = 1'b1;
            end
            2'b01: sw.tst = 1'b1;
            default: sw = SW_NONE;
        endcase
    end

    // Break and ringing paths are never requested together.
    always_comb a_no_brk_ring_r4: assert (!(sw.brk && sw.ring));

endmodule

// File: rtl/sw_off_seq.sv
// All-off sequencer and switch output register.
// In RUN the decoded set is registered.
// An override or thermal fault forces all-off. On an override the
// ringing switch is held until a zero crossing (break-before-make).
// Leaving all-off needs the override released and no fault.
// Assumes zc_pulse is a single-cycle, synchronous event.
module sw_off_seq
    import line_sw_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  sw_set_t dec_sw,
    input  logic    kill_n,
    input  logic    therm_fault,
    input  logic    zc_pulse,
    output sw_set_t sw_q,
    output logic    fault_n
);

    seq_state_t state_q, state_d;
    sw_set_t    sw_d;
    logic       armed_q;

    // Next state and next switch set.
    always_comb begin
        state_d = state_q;
        sw_d    = SW_NONE;
        unique case (state_q)
            ST_RUN: begin
                if (therm_fault) begin
                    state_d = ST_OFF;
                end else if (!kill_n) begin
                    sw_d.ring = sw_q.ring;
                    state_d   = sw_q.ring ? ST_WAIT_ZC : ST_OFF;
                end else begin
                    sw_d = dec_sw;
                end
            end
            ST_WAIT_ZC: begin
                if (therm_fault || zc_pulse) state_d   = ST_OFF;
                else                         sw_d.ring = 1'b1;
            end
            ST_OFF: begin
                if (kill_n && !therm_fault) begin
                    state_d = ST_RUN;
                    sw_d    = dec_sw;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State, switch and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            sw_q    <= SW_NONE;
            fault_n <= 1'b1;
        end else begin
            state_q <= state_d;
            sw_q    <= sw_d;
            fault_n <= !therm_fault;
        end
    end

    // Track the first cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R7: an override opens break, return and test on the next edge.
    p_kill_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !kill_n |=> (!sw_q.brk && !sw_q.rret && !sw_q.tst));

    // R7: nothing closes while the override stays low.
    p_no_close_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (!kill_n && $past(!kill_n)) |->
            !($rose(sw_q.brk) || $rose(sw_q.rret) || $rose(sw_q.ring) || $rose(sw_q.tst)));

    // R8: the ringing switch holds while waiting for a zero crossing.
    p_ring_waits_zc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_ZC && !zc_pulse && !therm_fault) |=> sw_q.ring);

    // R11: a thermal fault forces every switch off and signals the status.
    p_therm_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        therm_fault |=> (sw_q == SW_NONE && !fault_n));

    // R4: break and ringing switches never close together.
    p_brk_ring_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_q.brk && sw_q.ring));

endmodule

// File: rtl/line_sw_ctrl.sv
// Top level of the line switch state controller.
// Chain: mode latch -> decoder -> all-off sequencer with output register.
// Override and thermal inputs bypass the latch.
module line_sw_ctrl
    import line_sw_pkg::*;
#(
    parameter int CODE_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ring_sel,
    input  logic test_sel,
    input  logic hold_en,
    input  logic kill_n,
    input  logic therm_fault,
    input  logic zc_pulse,
    output logic brk_en,
    output logic rret_en,
    output logic ring_en,
    output logic tst_en,
    output logic fault_n
);

    logic [CODE_W-1:0] live_code;
    logic [CODE_W-1:0] eff_code;
    sw_set_t           dec_sw;
    sw_set_t           sw_q;

    // Pack the mode inputs into one code.
    always_comb live_code = {ring_sel, test_sel};

    sw_mode_latch #(.CODE_W(CODE_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .live_code(live_code),
        .hold_en  (hold_en),
        .eff_code (eff_code)
    );

    sw_mode_decode #(.CODE_W(CODE_W)) u_decode (
        .code(eff_code),
        .sw  (dec_sw)
    );

    sw_off_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_sw     (dec_sw),
        .kill_n     (kill_n),
        .therm_fault(therm_fault),
        .zc_pulse   (zc_pulse),
        .sw_q       (sw_q),
        .fault_n    (fault_n)
    );

    // Drive the switch enables from the registered set.
    always_comb begin
        brk_en  = sw_q.brk;
        rret_en = sw_q.rret;
        ring_en = sw_q.ring;
        tst_en  = sw_q.tst;
    end

endmodule

// File: tb/line_sw_ctrl_tb.sv
// Self-checking bench for line_sw_ctrl, with exhaustive code and latch sweeps.
module line_sw_ctrl_tb;

    logic clk = 1'b0;
    logic rst_n, ring_sel, test_sel, hold_en, kill_n, therm_fault, zc_pulse;
    logic brk_en, rret_en, ring_en, tst_en, fault_n;
    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;

    always #10 clk = ~clk;

    line_sw_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ring_sel(ring_sel), .test_sel(test_sel),
        .hold_en(hold_en), .kill_n(kill_n), .therm_fault(therm_fault),
        .zc_pulse(zc_pulse), .brk_en(brk_en), .rret_en(rret_en),
        .ring_en(ring_en), .tst_en(tst_en), .fault_n(fault_n)
    );

    // Expected {brk,rret,ring,tst} for code c = {ring,test}.
    function automatic logic [3:0] exp_of(input int c);
        int r = c / 2;
        int t = c % 2;
        logic [3:0] e;
        e[3] = (r == 0 && t == 0);
        e[2] = (r == 1 && t == 0);
        e[1] = (r == 1 && t == 0);
        e[0] = (r == 0 && t == 1);
        return e;
    endfunction

    task automatic drive(input int c, input logic h, input logic k,
                         input logic th, input logic z);
        @(negedge clk);
        ring_sel = c[1]; test_sel = c[0]; hold_en = h;
        kill_n = k; therm_fault = th; zc_pulse = z;
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [3:0] e, input logic ef);
        logic [3:0] a = {brk_en, rret_en, ring_en, tst_en};
        total++;
        if (a !== e || fault_n !== ef) begin
            bad++;
            $display("FAIL %s: sw=%b fault_n=%b expected sw=%b fault_n=%b",
                     req, a, fault_n, e, ef);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: sw=timeout expected sw=completion");
        finish_up();
    end

    initial begin
        rst_n = 1'b0;
        drive(3, 1'b0, 1'b1, 1'b0, 1'b0);
        settle(); settle();
        chk("R1 reset", 4'b0000, 1'b1);
        drive(0, 1'b0, 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        settle();

        // R4 R5 R6: decode of every code.
        for (int c = 0; c < 4; c++) begin
            drive(c, 1'b0, 1'b1, 1'b0, 1'b0); settle();
            chk(c == 2 ? "R4 ring" : c == 0 ? "R5 talk" : "R6 test/off",
                exp_of(c), 1'b1);
        end

        // R2: transparent pass-through for every code transition.
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
                drive(a, 1'b0, 1'b1, 1'b0, 1'b0); settle();
                drive(b, 1'b0, 1'b1, 1'b0, 1'b0); settle();
                chk("R2 transparent", exp_of(b), 1'b1);
            end

        // R3: freeze holds code a against new code b, then reopens (R2).
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
                drive(a, 1'b0, 1'b1, 1'b0, 1'b0); settle();
                drive(b, 1'b1, 1'b1, 1'b0, 1'b0); settle();
                chk("R3 hold", exp_of(a), 1'b1);
                drive(3 - b, 1'b1, 1'b1, 1'b0, 1'b0); settle();
                chk("R3 hold2", exp_of(a), 1'b1);
                drive(b, 1'b0, 1'b1, 1'b0, 1'b0); settle();
                chk("R2 reopen", exp_of(b), 1'b1);
            end

        // R7 R8: override from ringing waits for the zero crossing.
        drive(2, 1'b0, 1'b1, 1'b0, 1'b0); settle();
        chk("R4 ring pre", 4'b0110, 1'b1);
        drive(2, 1'b0, 1'b0, 1'b0, 1'b0); settle();
        chk("R7 override opens return", 4'b0010, 1'b1);
        for (int i = 0; i < 4; i++) begin
            drive(i, i[0], 1'b0, 1'b0, 1'b0); settle();
            chk("R8 ring held", 4'b0010, 1'b1);
        end
        drive(0, 1'b0, 1'b0, 1'b0, 1'b1); settle();
        chk("R8 zc opens ring", 4'b0000, 1'b1);
        drive(0, 1'b0, 1'b0, 1'b0, 1'b0); settle();
        chk("R7 stays off", 4'b0000, 1'b1);
        drive(0, 1'b0, 1'b1, 1'b0, 1'b0); settle();
        chk("R10 release talk", 4'b1000, 1'b1);

        // R9: override from talk needs no zero crossing.
        drive(0, 1'b0, 1'b0, 1'b0, 1'b0); settle();
        chk("R9 direct off", 4'b0000, 1'b1);
        drive(2, 1'b0, 1'b0, 1'b0, 1'b0); settle();
        chk("R9 off held", 4'b0000, 1'b1);
        drive(2, 1'b0, 1'b1, 1'b0, 1'b0); settle();
        chk("R10 release ring", 4'b0110, 1'b1);

        // R11: thermal fault drops the ringing switch at once.
        drive(2, 1'b0, 1'b1, 1'b1, 1'b0); settle();
        chk("R11 thermal", 4'b0000, 1'b0);
        drive(2, 1'b0, 1'b1, 1'b1, 1'b0); settle();
        chk("R10 blocked by fault", 4'b0000, 1'b0);
        drive(2, 1'b0, 1'b1, 1'b0, 1'b0); settle();
        chk("R10 fault clears", 4'b0110, 1'b1);

        // R11: thermal fault during the zero-crossing wait.
        drive(2, 1'b0, 1'b0, 1'b0, 1'b0); settle();
        chk("R8 wait", 4'b0010, 1'b1);
        drive(2, 1'b0, 1'b0, 1'b1, 1'b0); settle();
        chk("R11 fault in wait", 4'b0000, 1'b0);
        drive(1, 1'b0, 1'b1, 1'b0, 1'b0); settle();
        chk("R6 after recovery", 4'b0001, 1'b1);

        // R7: override ignores a frozen latch.
        drive(0, 1'b1, 1'b0, 1'b0, 1'b0); settle();
        chk("R7 over latch", 4'b0000, 1'b1);
        drive(0, 1'b1, 1'b1, 1'b0, 1'b0); settle();
        chk("R3 frozen after release", 4'b0001, 1'b1);

        finish_up();
    end

endmodule